// File: doc/BRIEF.md
# Pipelined Sign-Magnitude Signed Multiplier

This block multiplies a signed 11-bit operand by a signed 8-bit operand and returns the exact 19-bit two's-complement product. It accepts a new operand pair on any clock and returns one product per clock, eight clocks later. It is meant to sit inside transform datapaths where a pixel or intermediate term is scaled by a fixed-point coefficient. The block supplies only the multiply; the coefficient values come from elsewhere.

Each operand is first reduced to a sign bit and an unsigned magnitude. The magnitude of the wide operand is cut into a low part and a high part. Each part is multiplied by the narrow magnitude in its own stage, and the shifted sum is formed with the low half of the word one stage ahead of the high half. The product sign is the exclusive-OR of the operand signs. It travels beside the magnitude and is reapplied at the end by a split conditional negate. A final register forces a zero result to positive zero.

Top module: `smul_pipe`

## Requirements
- R1: For every pair of signed operands sampled with `in_valid` high, `out_p` equals the exact two's-complement product `in_a * in_b`, 19 bits wide.
- R2: The most negative operand values give their true magnitudes: -1024 x -128 = 131072, -1024 x 127 = -130048, 1023 x -128 = -130944.
- R3: When either operand is zero, `out_p` is all zeros, whatever the sign bits of the operands.
- R4: When the product is nonzero, bit 18 of `out_p` equals the XOR of bit 10 of `in_a` and bit 7 of `in_b`.
- R5: `out_valid` is high on exactly the cycle after the eighth rising edge, where the first of those edges is the edge that sampled `in_valid` high. It is low on every other cycle.
- R6: Operand pairs given on consecutive clocks produce results on consecutive clocks, in the same order, with no bubble.
- R7: Operands presented with `in_valid` low produce no result. While `out_valid` is low, `out_p` keeps the last product that was delivered.
- R8: While `rst_n` is low, `out_valid` is low and `out_p` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronous to clk |
| in_valid | input | 1 | Operand pair on in_a/in_b is valid this cycle |
| in_a | input | 11 | Signed multiplicand, two's complement |
| in_b | input | 8 | Signed multiplier, two's complement |
| out_valid | output | 1 | out_p carries a new product this cycle |
| out_p | output | 19 | Signed product, two's complement |

## Verification
Every product is due exactly eight rising edges after the edge that samples its operands. The same delay applies to `out_valid`, and to its absence for idle input slots. The bench keeps the expected value and validity of every input slot in arrays indexed by slot number. It drives a new slot on each falling edge and, on that same falling edge, compares the outputs against the slot entered eight iterations earlier. This ties each check to its fixed due cycle. A result that arrives one cycle early or late is compared against the wrong slot, and the check reports it.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Default operand widths of the multiplier
  localparam int unsigned DEF_A_W = 11;
  localparam int unsigned DEF_B_W = 8;

  // Fixed number of register levels from operand capture to product
  localparam int unsigned PIPE_DEPTH = 8;

  // Width of the lower half of a word cut into two carry-linked halves
  function automatic int unsigned lower_half(input int unsigned w);
    return w / 2;
  endfunction

endpackage

// File: rtl/smul_signmag.sv
// Two's-complement to sign/magnitude conversion (combinational).
// The most negative value maps to 2**(W-1), which still fits in W bits unsigned.
module smul_signmag #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);

  always_comb begin
    neg_o = val_i[W-1];
    if (val_i[W-1]) begin
      mag_o = ~val_i + {{(W-1){1'b0}}, 1'b1};
    end else begin
      mag_o = val_i;
    end
  end

endmodule

// File: rtl/smul_magmul.sv
// Magnitude product: two partial products (low / high slice of A),
// then a shifted sum formed low half first, high half one level later.
// Four register levels.
module smul_magmul #(
  parameter int unsigned A_W = 11,
  parameter int unsigned B_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic                 sgn_i,
  input  logic [A_W-1:0]       ma_i,
  input  logic [B_W-1:0]       mb_i,
  output logic                 v_o,
  output logic                 sgn_o,
  output logic [A_W+B_W-1:0]   mag_o
);

  localparam int unsigned M_W   = A_W + B_W;
  localparam int unsigned LO_W  = smul_pkg::lower_half(A_W);
  localparam int unsigned HI_W  = A_W - LO_W;
  localparam int unsigned PL_W  = LO_W + B_W;
  localparam int unsigned PH_W  = HI_W + B_W;
  localparam int unsigned SPL_W = smul_pkg::lower_half(M_W);
  localparam int unsigned UP_W  = M_W - SPL_W;

  // ---------------- level A: low partial product ----------------
  logic              la_v;
  logic              la_s,  la_s_d;
  logic [PL_W-1:0]   la_pl, la_pl_d;
  logic [HI_W-1:0]   la_ah, la_ah_d;
  logic [B_W-1:0]    la_b,  la_b_d;

  always_comb begin
    la_pl_d = {{B_W{1'b0}}, ma_i[LO_W-1:0]} * {{LO_W{1'b0}}, mb_i};
    la_ah_d = ma_i[A_W-1:LO_W];
    la_b_d  = mb_i;
    la_s_d  = sgn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_v  <= 1'b0;
      la_s  <= 1'b0;
      la_pl <= '0;
      la_ah <= '0;
      la_b  <= '0;
    end else begin
      la_v <= v_i;
      if (v_i) begin
        la_s  <= la_s_d;
        la_pl <= la_pl_d;
        la_ah <= la_ah_d;
        la_b  <= la_b_d;
      end
    end
  end

  // ---------------- level B: high partial product ----------------
  logic              lb_v;
  logic              lb_s;
  logic [PL_W-1:0]   lb_pl;
  logic [PH_W-1:0]   lb_ph, lb_ph_d;

  always_comb begin
    lb_ph_d = {{B_W{1'b0}}, la_ah} * {{HI_W{1'b0}}, la_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_v  <= 1'b0;
      lb_s  <= 1'b0;
      lb_pl <= '0;
      lb_ph <= '0;
    end else begin
      lb_v <= la_v;
      if (la_v) begin
        lb_s  <= la_s;
        lb_pl <= la_pl;
        lb_ph <= lb_ph_d;
      end
    end
  end

  // ---------------- level C: low half of shifted sum ----------------
  logic [M_W-1:0]    lo_ext, hi_sh;
  logic [SPL_W:0]    lc_sum_d;
  logic              lc_v;
  logic              lc_s;
  logic [SPL_W-1:0]  lc_lo;
  logic              lc_c;
  logic [UP_W-1:0]   lc_lu, lc_hu;

  always_comb begin
    lo_ext   = {{(M_W-PL_W){1'b0}}, lb_pl};
    hi_sh    = {lb_ph, {LO_W{1'b0}}};
    lc_sum_d = {1'b0, lo_ext[SPL_W-1:0]} + {1'b0, hi_sh[SPL_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_v  <= 1'b0;
      lc_s  <= 1'b0;
      lc_lo <= '0;
      lc_c  <= 1'b0;
      lc_lu <= '0;
      lc_hu <= '0;
    end else begin
      lc_v <= lb_v;
      if (lb_v) begin
        lc_s  <= lb_s;
        lc_lo <= lc_sum_d[SPL_W-1:0];
        lc_c  <= lc_sum_d[SPL_W];
        lc_lu <= lo_ext[M_W-1:SPL_W];
        lc_hu <= hi_sh[M_W-1:SPL_W];
      end
    end
  end

  // ---------------- level D: high half of shifted sum ----------------
  logic [UP_W-1:0]   ld_up_d;
  logic              ld_v;
  logic              ld_s;
  logic [M_W-1:0]    ld_mag;

  always_comb begin
    ld_up_d = lc_lu + lc_hu + {{(UP_W-1){1'b0}}, lc_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_v   <= 1'b0;
      ld_s   <= 1'b0;
      ld_mag <= '0;
    end else begin
      ld_v <= lc_v;
      if (lc_v) begin
        ld_s   <= lc_s;
        ld_mag <= {ld_up_d, lc_lo};
      end
    end
  end

  assign v_o   = ld_v;
  assign sgn_o = ld_s;
  assign mag_o = ld_mag;

endmodule

// File: rtl/smul_resign.sv
// Reapplies the product sign: conditional negate split over two levels
// (low half, then high half with carry), then a result register that
// forces a zero magnitude to +0. Three register levels.
module smul_resign #(
  parameter int unsigned M_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            v_i,
  input  logic            sgn_i,
  input  logic [M_W-1:0]  mag_i,
  output logic            v_o,
  output logic [M_W-1:0]  p_o
);

  localparam int unsigned SPL_W = smul_pkg::lower_half(M_W);
  localparam int unsigned UP_W  = M_W - SPL_W;

  // ---------------- level E: invert, add sign to low half ----------------
  logic [M_W-1:0]    inv_d;
  logic [SPL_W:0]    le_lo_d;
  logic              le_v;
  logic [SPL_W-1:0]  le_lo;
  logic              le_c;
  logic [UP_W-1:0]   le_xu;
  logic              le_z;

  always_comb begin
    inv_d   = mag_i ^ {M_W{sgn_i}};
    le_lo_d = {1'b0, inv_d[SPL_W-1:0]} + {{SPL_W{1'b0}}, sgn_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_v  <= 1'b0;
      le_lo <= '0;
      le_c  <= 1'b0;
      le_xu <= '0;
      le_z  <= 1'b0;
    end else begin
      le_v <= v_i;
      if (v_i) begin
        le_lo <= le_lo_d[SPL_W-1:0];
        le_c  <= le_lo_d[SPL_W];
        le_xu <= inv_d[M_W-1:SPL_W];
        le_z  <= (mag_i == '0);
      end
    end
  end

  // ---------------- level F: carry into high half ----------------
  logic [UP_W-1:0]   lf_up_d;
  logic              lf_v;
  logic [M_W-1:0]    lf_p;
  logic              lf_z;

  always_comb begin
    lf_up_d = le_xu + {{(UP_W-1){1'b0}}, le_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_v <= 1'b0;
      lf_p <= '0;
      lf_z <= 1'b0;
    end else begin
      lf_v <= le_v;
      if (le_v) begin
        lf_p <= {lf_up_d, le_lo};
        lf_z <= le_z;
      end
    end
  end

  // ---------------- level G: result register ----------------
  logic [M_W-1:0]    lg_p_d;
  logic              lg_v;
  logic [M_W-1:0]    lg_p;

  always_comb begin
    lg_p_d = lf_z ? '0 : lf_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_v <= 1'b0;
      lg_p <= '0;
    end else begin
      lg_v <= lf_v;
      if (lf_v) begin
        lg_p <= lg_p_d;
      end
    end
  end

  assign v_o = lg_v;
  assign p_o = lg_p;

endmodule

// File: rtl/smul_pipe.sv
// Eight-level signed multiplier: capture (1) + magnitude multiply (4)
// + sign reapplication (3).
module smul_pipe #(
  parameter int unsigned A_W = smul_pkg::DEF_A_W,
  parameter int unsigned B_W = smul_pkg::DEF_B_W,
  parameter int unsigned P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [A_W-1:0] in_a,
  input  logic [B_W-1:0] in_b,
  output logic           out_valid,
  output logic [P_W-1:0] out_p
);

  // ---------------- operand capture level ----------------
  logic           a_neg, b_neg;
  logic [A_W-1:0] a_mag;
  logic [B_W-1:0] b_mag;

  smul_signmag #(.W(A_W)) u_abs_a (.val_i(in_a), .neg_o(a_neg), .mag_o(a_mag));
  smul_signmag #(.W(B_W)) u_abs_b (.val_i(in_b), .neg_o(b_neg), .mag_o(b_mag));

  logic           cap_v;
  logic           cap_s,  cap_s_d;
  logic [A_W-1:0] cap_ma;
  logic [B_W-1:0] cap_mb;

  always_comb begin
    cap_s_d = a_neg ^ b_neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v  <= 1'b0;
      cap_s  <= 1'b0;
      cap_ma <= '0;
      cap_mb <= '0;
    end else begin
      cap_v <= in_valid;
      if (in_valid) begin
        cap_s  <= cap_s_d;
        cap_ma <= a_mag;
        cap_mb <= b_mag;
      end
    end
  end

  // ---------------- magnitude multiply ----------------
  logic               mm_v, mm_s;
  logic [P_W-1:0]     mm_mag;

  smul_magmul #(.A_W(A_W), .B_W(B_W)) u_magmul (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (cap_v),
    .sgn_i (cap_s),
    .ma_i  (cap_ma),
    .mb_i  (cap_mb),
    .v_o   (mm_v),
    .sgn_o (mm_s),
    .mag_o (mm_mag)
  );

  // ---------------- sign reapplication ----------------
  smul_resign #(.M_W(P_W)) u_resign (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (mm_v),
    .sgn_i (mm_s),
    .mag_i (mm_mag),
    .v_o   (out_valid),
    .p_o   (out_p)
  );

endmodule

// File: rtl/smul_pipe_chk.sv
module smul_pipe_chk #(
  parameter int unsigned A_W = 11,
  parameter int unsigned B_W = 8,
  parameter int unsigned P_W = A_W + B_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [A_W-1:0] in_a,
  input logic [B_W-1:0] in_b,
  input logic           out_valid,
  input logic [P_W-1:0] out_p
);

  localparam int unsigned DEPTH = smul_pkg::PIPE_DEPTH;

  // cycles since reset, saturating at the pipeline depth
  logic [4:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age < 5'(DEPTH)) age <= age + 5'd1;
  end
  logic warm;
  assign warm = (age == 5'(DEPTH));

  logic signed [P_W-1:0] ref_p;
  logic                  op_zero;
  logic                  sgn_x;
  always_comb begin
    ref_p   = P_W'($signed(in_a)) * P_W'($signed(in_b));
    op_zero = (in_a == '0) || (in_b == '0);
    sgn_x   = in_a[A_W-1] ^ in_b[B_W-1];
  end

  // R8
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid && out_p == '0);
    end
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 8)));

  // R1
  product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> ($signed(out_p) == $past(ref_p, 8)));

  // R3
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(op_zero, 8)) |-> (out_p == '0));

  // R4
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && out_p != '0) |-> (out_p[P_W-1] == $past(sgn_x, 8)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !out_valid) |-> $stable(out_p));

endmodule

bind smul_pipe smul_pipe_chk #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_p     (out_p)
);

// File: tb/test_smul_pipe.sv
`timescale 1ns/1ps
module test_smul_pipe;

  localparam int A_W = 11;
  localparam int B_W = 8;
  localparam int P_W = A_W + B_W;
  localparam int LAT = 8;
  localparam int N   = 700;
  localparam int NDIR = 14;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [A_W-1:0] in_a;
  logic [B_W-1:0] in_b;
  logic           out_valid;
  logic [P_W-1:0] out_p;

  always #5 clk = ~clk;

  smul_pipe i_smul_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_p(out_p)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic           ev [N];
  logic [P_W-1:0] ep [N];
  logic [A_W-1:0] ea [N];
  logic [B_W-1:0] eb [N];

  task automatic chk(input bit ok, input string req, input logic [P_W-1:0] act,
                     input logic [P_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h) at %0t",
               req, $signed(act), act, $signed(exp), exp, $time);
    end
  endtask

  function automatic logic [P_W-1:0] model(input logic [A_W-1:0] a, input logic [B_W-1:0] b);
    longint pa, pb;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    return P_W'(pa * pb);
  endfunction

  function automatic int dir_a(input int k);
    case (k)
      0: return -1024;  1: return -1024;  2: return 1023;   3: return 1023;
      4: return 0;      5: return -1024;  6: return -1;     7: return -1;
      8: return 5;      9: return 0;      10: return -1;    11: return 1;
      12: return -512;  default: return 341;
    endcase
  endfunction

  function automatic int dir_b(input int k);
    case (k)
      0: return -128;   1: return 127;    2: return -128;   3: return 127;
      4: return -128;   5: return 0;      6: return -1;     7: return 1;
      8: return -3;     9: return 0;      10: return 0;     11: return -1;
      12: return 64;    default: return -85;
    endcase
  endfunction

  initial begin : main
    int unsigned seed_init;
    logic [P_W-1:0] last_p;
    seed_init = $urandom(32'd4242);
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    last_p = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 out_valid in reset", P_W'(out_valid), '0);
    chk(out_p == '0, "R8 out_p in reset", out_p, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int j = 0; j < N + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT) begin
        int s;
        s = j - LAT;
        // R5: validity exactly LAT edges later
        chk(out_valid == ev[s], "R5 out_valid timing", P_W'(out_valid), P_W'(ev[s]));
        if (ev[s]) begin
          if (ea[s] == '0 || eb[s] == '0)
            chk(out_p == '0, "R3 zero product", out_p, '0);
          else if (ea[s] == 11'h400 || eb[s] == 8'h80)
            chk(out_p == ep[s], "R2 extreme operand", out_p, ep[s]);
          else if (s < 40)
            chk(out_p == ep[s], "R6 back-to-back product", out_p, ep[s]);
          else
            chk(out_p == ep[s], "R1 product", out_p, ep[s]);
          if (ep[s] != '0)
            chk(out_p[P_W-1] == (ea[s][A_W-1] ^ eb[s][B_W-1]), "R4 sign bit",
                P_W'(out_p[P_W-1]), P_W'(ea[s][A_W-1] ^ eb[s][B_W-1]));
          last_p = ep[s];
        end else begin
          // R7: idle slot leaves the last product in place
          chk(out_p == last_p, "R7 hold on idle", out_p, last_p);
        end
      end else begin
        chk(out_valid == 1'b0, "R5 no early out_valid", P_W'(out_valid), '0);
      end

      if (j < N) begin
        logic v;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        if (j < NDIR) begin
          v = 1'b1;
          a = A_W'(dir_a(j));
          b = B_W'(dir_b(j));
        end else begin
          v = (j < 40) ? 1'b1 : ($urandom % 4 != 0);
          a = A_W'($urandom);
          b = B_W'($urandom);
          if ($urandom % 16 == 0) a = 11'h400;
          if ($urandom % 16 == 0) b = 8'h80;
          if ($urandom % 20 == 0) a = '0;
        end
        ev[j] = v; ea[j] = a; eb[j] = b;
        ep[j] = v ? model(a, b) : '0;
        in_valid = v; in_a = a; in_b = b;
      end else begin
        in_valid = 1'b0;
        in_a = A_W'($urandom);
        in_b = B_W'($urandom);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule